// File: doc/BRIEF.md
# Bloom-Filtered Memory Search Gate

This block stands in front of an associative load/store queue and decides, for every executing memory operation, whether that queue has to be searched for an address match. Each request carries a physical address. The address is hashed to one slot of a 64-slot membership filter. When the slot already shows an in-flight address, the block asks for a search, because a match is possible though not certain. When the slot is empty, a match is impossible, so the block reports that no search is needed and marks the slot as occupied.

Each slot holds a small saturating counter rather than a single bit, so retiring or squashed operations can be taken out again through a removal port. A flush input empties the whole filter in one cycle. The decision is registered and appears one cycle after its request. The filter only gates the search. Every memory operation still receives a queue entry, so allocation does not depend on the decision.

Top module: `memsearch_gate`

## Requirements
- R1: The slot index is the 6-bit XOR of address bits [7:2] and address bits [13:8]. Addresses with equal indices share one slot, and bits [1:0] and bits above 13 have no effect.
- R2: `search_valid` is high exactly in the cycle after a cycle with `req_valid` high. `search_req` is low whenever `search_valid` is low.
- R3: A request whose slot counter is zero yields `search_req` = 0, and the counter becomes one, so a following request to that slot asks for a search. The filter never gives a false negative.
- R4: A request whose slot counter is non-zero yields `search_req` = 1, and the counter goes up by one unless it is saturated.
- R5: A removal whose slot counter is non-zero and below saturation lowers that counter by one.
- R6: A removal whose slot counter is zero changes nothing.
- R7: When a request and a removal hit the same slot in one cycle, the counter keeps its value. The request's decision still comes from the counter value before that cycle.
- R8: A counter at its maximum (3 for 2-bit counters) ignores further requests and removals and is cleared only by a flush.
- R9: A flush zeroes every counter in one cycle. A request in the flush cycle gets `search_req` = 1 and is not inserted, and a removal in that cycle is discarded.
- R10: While `rst_n` is low, both outputs are low and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | An executing load or store presents an address |
| req_addr | input | 32 | Physical address of the executing operation |
| rmv_valid | input | 1 | A retiring or squashed operation leaves the filter |
| rmv_addr | input | 32 | Physical address of the leaving operation |
| flush | input | 1 | Empty the whole filter |
| search_valid | output | 1 | Decision valid, one cycle after the request |
| search_req | output | 1 | The associative queue must be searched |

## Verification
Each decision is due one clock edge after its request. The bench drives a request away from the edge, advances its reference counters at that edge, and compares `search_valid` and `search_req` just after the edge. Counter updates from requests, removals and flushes only become visible through the next request's decision. For that reason the ordering, saturation and flush cases are each followed by a probe request, and the check that matters falls on that probe's decision one cycle later.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [1:0] {
    SLOT_HOLD = 2'd0,
    SLOT_INC  = 2'd1,
    SLOT_DEC  = 2'd2,
    SLOT_CLR  = 2'd3
  } slot_op_e;
endpackage

// File: rtl/bf_index_hash.sv
module bf_index_hash #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int LO_BASE = OFS_W;
  localparam int HI_BASE = OFS_W + IDX_W;

  logic [IDX_W-1:0] slice_lo;
  logic [IDX_W-1:0] slice_hi;

  always_comb begin
    slice_lo = addr[LO_BASE +: IDX_W];
    slice_hi = addr[HI_BASE +: IDX_W];
    idx      = slice_lo ^ slice_hi;
  end
endmodule

// File: rtl/bf_slot.sv
module bf_slot
  import bf_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  slot_op_e op,
  output logic     nonzero,
  output logic     saturated
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (op)
      SLOT_INC: if (cnt_q != CNT_MAX) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
      SLOT_DEC: if (cnt_q != CNT_MAX && cnt_q != '0) begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
      SLOT_CLR: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      default: begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nonzero   = (cnt_q != '0);
  assign saturated = (cnt_q == CNT_MAX);

  assert_sat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (saturated && op != SLOT_CLR) |=> saturated);

  assert_zero_dec_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!nonzero && op == SLOT_DEC) |=> !nonzero);
endmodule

// File: rtl/bf_slot_array.sv
module bf_slot_array
  import bf_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_en,
  input  logic [IDX_W-1:0]      ins_idx,
  input  logic                  rmv_en,
  input  logic [IDX_W-1:0]      rmv_idx,
  input  logic                  clr_all,
  output logic [(1<<IDX_W)-1:0] occupied
);
  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] sat_vec;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    slot_op_e op;
    logic     ins_hit;
    logic     rmv_hit;

    always_comb begin
      ins_hit = ins_en && (ins_idx == IDX_W'(s));
      rmv_hit = rmv_en && (rmv_idx == IDX_W'(s));
      if (clr_all)                op = SLOT_CLR;
      else if (ins_hit && rmv_hit) op = SLOT_HOLD;
      else if (ins_hit)           op = SLOT_INC;
      else if (rmv_hit)           op = SLOT_DEC;
      else                        op = SLOT_HOLD;
    end

    bf_slot #(.CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .nonzero  (occupied[s]),
      .saturated(sat_vec[s])
    );
  end

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (occupied == '0));

  assert_sat_implies_occupied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sat_vec & ~occupied) == '0));
endmodule

// File: rtl/memsearch_gate.sv
module memsearch_gate #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rmv_valid,
  input  logic [ADDR_W-1:0] rmv_addr,
  input  logic              flush,
  output logic              search_valid,
  output logic              search_req
);
  localparam int SLOTS = 1 << IDX_W;

  logic [IDX_W-1:0] req_idx;
  logic [IDX_W-1:0] rmv_idx;
  logic [SLOTS-1:0] occupied;
  logic             valid_d;
  logic             req_d;

  bf_index_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_req_hash (
    .addr(req_addr),
    .idx (req_idx)
  );

  bf_index_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_rmv_hash (
    .addr(rmv_addr),
    .idx (rmv_idx)
  );

  bf_slot_array #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_en  (req_valid),
    .ins_idx (req_idx),
    .rmv_en  (rmv_valid),
    .rmv_idx (rmv_idx),
    .clr_all (flush),
    .occupied(occupied)
  );

  always_comb begin
    valid_d = req_valid;
    req_d   = req_valid && (flush || occupied[req_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      search_valid <= 1'b0;
      search_req   <= 1'b0;
    end else begin
      search_valid <= valid_d;
      search_req   <= req_d;
    end
  end

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> search_valid);

  assert_idle_no_decision_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!search_valid && !search_req));

  assert_insert_marks_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flush && !(rmv_valid && rmv_idx == req_idx))
      |=> occupied[$past(req_idx)]);

  assert_flush_forces_search_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && flush) |=> search_req);
endmodule

// File: tb/memsearch_gate_tb.sv
module memsearch_gate_tb;
  localparam int CMAX = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rmv_valid;
  logic [31:0] rmv_addr;
  logic        flush;
  logic        search_valid;
  logic        search_req;

  int vectors;
  int errors;
  int ref_cnt [64];

  memsearch_gate u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .rmv_valid   (rmv_valid),
    .rmv_addr    (rmv_addr),
    .flush       (flush),
    .search_valid(search_valid),
    .search_req  (search_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int hidx(input logic [31:0] a);
    return int'((a >> 2) & 32'h3f) ^ int'((a >> 8) & 32'h3f);
  endfunction

  task automatic compare(input string tag, input logic ev, input logic er);
    vectors++;
    if (search_valid !== ev || search_req !== er) begin
      errors++;
      $display("FAIL %s: valid/req actual %b/%b expected %b/%b",
               tag, search_valid, search_req, ev, er);
    end
  endtask

  // One cycle: drive, advance the reference at the edge, compare after it.
  task automatic step(input string tag, input logic rv, input logic [31:0] ra,
                      input logic mv, input logic [31:0] ma, input logic fl);
    int  qi;
    int  ri;
    logic er;
    req_valid = rv; req_addr = ra; rmv_valid = mv; rmv_addr = ma; flush = fl;
    qi = hidx(ra);
    ri = hidx(ma);
    er = rv && (fl || ref_cnt[qi] != 0);
    if (fl) begin
      for (int i = 0; i < 64; i++) ref_cnt[i] = 0;
    end else if (!(rv && mv && qi == ri)) begin
      if (rv && ref_cnt[qi] < CMAX) ref_cnt[qi]++;
      if (mv && ref_cnt[ri] != 0 && ref_cnt[ri] < CMAX) ref_cnt[ri]--;
    end
    @(posedge clk);
    #1;
    compare(tag, rv, er);
  endtask

  task automatic ins(input string tag, input logic [31:0] a);
    step(tag, 1'b1, a, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic rmv(input string tag, input logic [31:0] a);
    step(tag, 1'b0, 32'h0, 1'b1, a, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [31:0] b;
    vectors = 0;
    errors  = 0;
    for (int i = 0; i < 64; i++) ref_cnt[i] = 0;
    rst_n = 1'b0;
    req_valid = 1'b1; req_addr = 32'h40; rmv_valid = 1'b0; rmv_addr = '0; flush = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    compare("R10 reset", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    compare("R10 after reset", 1'b0, 1'b0);

    a = 32'h0000_0040;                 // slot 16
    b = 32'h0000_0144;                 // alias of slot 16
    step("R2 idle", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    ins("R3 first insert", a);
    ins("R4 repeat hit", a);
    ins("R1 alias shares slot", b);
    ins("R1 offset bits ignored", a | 32'h3);
    ins("R1 high bits ignored", a | 32'hffff_c000);
    rmv("R8 remove at max", a);
    ins("R8 saturated still hit", a);
    step("R9 flush", 1'b0, 32'h0, 1'b0, 32'h0, 1'b1);
    ins("R9 empty after flush", b);
    rmv("R5 decrement", a);
    ins("R5 slot free again", a);
    step("R7 same slot ins+rmv", 1'b1, a, 1'b1, b, 1'b0);
    rmv("R5 remove", a);
    rmv("R6 remove at zero", a);
    ins("R6 zero remove ignored", a);
    ins("R4 second", a);
    rmv("R5 down", a);
    rmv("R5 down to zero", a);
    step("R7 ins+rmv zero slot", 1'b1, a, 1'b1, a, 1'b0);
    ins("R7 count unchanged", a);
    step("R9 req during flush", 1'b1, 32'h80, 1'b1, a, 1'b1);
    ins("R9 flush req not inserted", 32'h80);
    step("R9 flush clears", 1'b0, 32'h0, 1'b0, 32'h0, 1'b1);

    for (int n = 0; n < 2000; n++) begin
      logic rv;
      logic mv;
      logic fl;
      rv = ($urandom % 4) != 0;
      mv = ($urandom % 3) == 0;
      fl = ($urandom % 97) == 0;
      step("R1 random traffic", rv, $urandom & 32'h0000_0ffc | ($urandom % 4),
           mv, $urandom & 32'h0000_0ffc, fl);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule